// File: doc/BRIEF.md
# Bi-Endian Aligned Load/Store Port

This block sits between a processor core and a small on-chip byte RAM of 2^ADDR_BITS bytes. The core issues one request per cycle: a read or write of 8, 16 or 32 bits at a byte address. The block stores and fetches the bytes in the order chosen by a static endianness input. It returns read results one cycle later, either zero-extended or sign-extended to 32 bits.

Each access width has a single address mask. The mask does two jobs at once. Address bits above the RAM size must be zero, and the low bits that a wider access needs to be aligned must also be zero. Any set bit outside the mask raises a one-cycle bus-error pulse, and the access is then dropped. Byte writes above a fixed I/O threshold are also copied onto an I/O write port, so a console or similar peripheral can observe them.

Top module: `bimem_port`

## Requirements
- R1: After reset `rdValid` is low and every RAM byte reads back as zero.
- R2: `reqSize` encodes the width: 0 is byte, 1 is 16-bit, 2 or 3 is 32-bit. The byte mask is 2^ADDR_BITS-1. The 16-bit mask also clears bit 0, and the 32-bit mask also clears bits 1 and 0. `busError` is high in the same cycle as a valid request whose address has any bit set outside its width mask. It is never high without `reqValid`.
- R3: A write that raises `busError` leaves the RAM unchanged.
- R4: With `bigEndian`=0, the lowest address of a 16-bit or 32-bit access holds the least significant byte.
- R5: With `bigEndian`=1, the lowest address of a 16-bit or 32-bit access holds the most significant byte.
- R6: Byte accesses give the same result in either endian mode.
- R7: An error-free read raises `rdValid` for one cycle, on the cycle after the request, with the result on `rdData`. Writes and erroring reads never raise `rdValid`.
- R8: With `reqSigned`=1, a byte result is sign-extended from bit 7 and a 16-bit result from bit 15. With `reqSigned`=0, the upper bits are zero.
- R9: A byte write whose address is strictly above IO_BASE (default 0x5000000) raises `ioWrite` in the same cycle, with `ioAddr`=`reqAddr` and `ioData`=`reqWdata[7:0]`. This happens whether or not `busError` is raised. Reads and 16-bit or 32-bit writes never raise `ioWrite`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bigEndian | input | 1 | Static byte order: 1 = most significant byte at lowest address |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | Access width code |
| reqSigned | input | 1 | Sign-extend read results |
| reqAddr | input | 32 | Byte address |
| reqWdata | input | 32 | Write data, right-aligned |
| busError | output | 1 | Misaligned or out-of-range access pulse |
| rdValid | output | 1 | Read result valid |
| rdData | output | 32 | Extended read result |
| ioWrite | output | 1 | I/O byte write strobe |
| ioAddr | output | 32 | I/O write address |
| ioData | output | 8 | I/O write byte |

## Verification
Directed patterns each target one behaviour. A known 32-bit word written in each byte order and read back as single bytes shows whether the lanes are steered correctly. Addresses with a bit set just above the RAM size are checked apart from merely misaligned ones, to show that one mask catches both. A read-back after a refused write shows whether the write was really dropped. Byte and halfword values with the top bit set show the difference between sign extension and zero extension, and addresses at and just above the I/O threshold pin down its strict comparison. A seeded random mix of widths, alignments and both byte orders is then checked against a byte-level model of the RAM in the bench.

// File: rtl/bimem_pkg.sv
package bimem_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic      wrEn;
    logic      rdEn;
    logic      ioEn;
    acc_size_e size;
    logic      sext;
    logic      big;
  } strobe_t;

endpackage

// File: rtl/bimem_ctrl.sv
module bimem_ctrl
  import bimem_pkg::*;
#(
  parameter int          ADDR_BITS = 10,
  parameter int          AW        = 32,
  parameter logic [31:0] IO_BASE   = 32'h0500_0000
) (
  input  logic                 bigEndian,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [1:0]           reqSize,
  input  logic                 reqSigned,
  input  logic [AW-1:0]        reqAddr,
  output logic                 busError,
  output strobe_t              strb,
  output logic [ADDR_BITS-1:0] memAddr
);

  localparam logic [AW-1:0] MASK_B = AW'((64'd1 << ADDR_BITS) - 64'd1);
  localparam logic [AW-1:0] MASK_H = MASK_B & ~AW'(1);
  localparam logic [AW-1:0] MASK_W = MASK_B & ~AW'(3);

  acc_size_e     sz;
  logic [AW-1:0] widthMask;

  assign sz = acc_size_e'(reqSize);

  always_comb begin
    unique case (sz)
      SZ_BYTE: widthMask = MASK_B;
      SZ_HALF: widthMask = MASK_H;
      default: widthMask = MASK_W;
    endcase
  end

  assign busError = reqValid && ((reqAddr & ~widthMask) != '0);
  assign memAddr  = reqAddr[ADDR_BITS-1:0];

  always_comb begin
    strb.wrEn = reqValid && reqWrite && !busError;
    strb.rdEn = reqValid && !reqWrite && !busError;
    strb.ioEn = reqValid && reqWrite && (sz == SZ_BYTE) && (reqAddr > AW'(IO_BASE));
    strb.size = sz;
    strb.sext = reqSigned;
    strb.big  = bigEndian;
  end

endmodule

// File: rtl/bimem_datapath.sv
module bimem_datapath
  import bimem_pkg::*;
#(
  parameter int ADDR_BITS = 10,
  parameter int DW        = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [ADDR_BITS-1:0] memAddr,
  input  logic [DW-1:0]        wdata,
  output logic                 rdValid,
  output logic [DW-1:0]        rdData
);

  localparam int MEM_BYTES = 1 << ADDR_BITS;
  localparam int LANES     = DW / 8;

  logic [7:0] mem [MEM_BYTES];
  logic [7:0] wrLane [LANES];
  logic [7:0] rdLane [LANES];
  logic [LANES-1:0] laneEn;
  logic [DW-1:0] shaped;

  always_comb begin
    unique case (strb.size)
      SZ_BYTE: laneEn = LANES'(1);
      SZ_HALF: laneEn = LANES'(3);
      default: laneEn = '1;
    endcase
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      if (!strb.big || strb.size == SZ_BYTE)
        wrLane[k] = wdata[8*k +: 8];
      else if (strb.size == SZ_HALF)
        wrLane[k] = wdata[8*((1 - k) & 1) +: 8];
      else
        wrLane[k] = wdata[8*(LANES-1-k) +: 8];
    end
    assign rdLane[k] = mem[ADDR_BITS'(memAddr + ADDR_BITS'(k))];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
    end else if (strb.wrEn) begin
      for (int k = 0; k < LANES; k++)
        if (laneEn[k]) mem[ADDR_BITS'(memAddr + ADDR_BITS'(k))] <= wrLane[k];
    end
  end

  always_comb begin
    unique case (strb.size)
      SZ_BYTE: shaped = {{(DW-8){strb.sext & rdLane[0][7]}}, rdLane[0]};
      SZ_HALF: begin
        if (strb.big)
          shaped = {{(DW-16){strb.sext & rdLane[0][7]}}, rdLane[0], rdLane[1]};
        else
          shaped = {{(DW-16){strb.sext & rdLane[1][7]}}, rdLane[1], rdLane[0]};
      end
      default: begin
        for (int k = 0; k < LANES; k++)
          shaped[8*k +: 8] = strb.big ? rdLane[LANES-1-k] : rdLane[k];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.rdEn;
      if (strb.rdEn) rdData <= shaped;
    end
  end

endmodule

// File: rtl/bimem_port.sv
module bimem_port
  import bimem_pkg::*;
#(
  parameter int          ADDR_BITS = 10,
  parameter logic [31:0] IO_BASE   = 32'h0500_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bigEndian,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [1:0]  reqSize,
  input  logic        reqSigned,
  input  logic [31:0] reqAddr,
  input  logic [31:0] reqWdata,
  output logic        busError,
  output logic        rdValid,
  output logic [31:0] rdData,
  output logic        ioWrite,
  output logic [31:0] ioAddr,
  output logic [7:0]  ioData
);

  strobe_t              strb;
  logic [ADDR_BITS-1:0] memAddr;

  bimem_ctrl #(.ADDR_BITS(ADDR_BITS), .AW(32), .IO_BASE(IO_BASE)) u_ctrl (
    .bigEndian(bigEndian), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqSigned(reqSigned), .reqAddr(reqAddr),
    .busError(busError), .strb(strb), .memAddr(memAddr)
  );

  bimem_datapath #(.ADDR_BITS(ADDR_BITS), .DW(32)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .memAddr(memAddr),
    .wdata(reqWdata), .rdValid(rdValid), .rdData(rdData)
  );

  assign ioWrite = strb.ioEn;
  assign ioAddr  = reqAddr;
  assign ioData  = reqWdata[7:0];

endmodule

// File: rtl/bimem_port_chk.sv
module bimem_port_chk #(
  parameter logic [31:0] IO_BASE = 32'h0500_0000
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [1:0]  reqSize,
  input logic        reqSigned,
  input logic [31:0] reqAddr,
  input logic        busError,
  input logic        rdValid,
  input logic [31:0] rdData,
  input logic        ioWrite
);

  a_r2_err_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    busError |-> reqValid);

  a_r2_word_misalign: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize[1] && reqAddr[1:0] != 2'b00) |-> busError);

  a_r2_half_misalign: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd1 && reqAddr[0]) |-> busError);

  a_r7_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && !busError) |=> rdValid);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid || reqWrite || busError) |=> !rdValid);

  a_r8_zero_ext_byte: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && !busError && reqSize == 2'd0 && !reqSigned)
      |=> (rdData[31:8] == 24'd0));

  a_r9_io_byte_write: assert property (@(posedge clk) disable iff (!rstN)
    ioWrite |-> (reqValid && reqWrite && reqSize == 2'd0 && reqAddr > IO_BASE));

endmodule

bind bimem_port bimem_port_chk #(.IO_BASE(IO_BASE)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqSize(reqSize), .reqSigned(reqSigned), .reqAddr(reqAddr),
  .busError(busError), .rdValid(rdValid), .rdData(rdData), .ioWrite(ioWrite)
);

// File: tb/bimem_port_tb.sv
module bimem_port_tb;

  localparam int          AB      = 10;
  localparam int          NB      = 1 << AB;
  localparam logic [31:0] IO_BASE = 32'h0500_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bigEndian = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic        reqSigned = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        busError, rdValid, ioWrite;
  logic [31:0] rdData, ioAddr;
  logic [7:0]  ioData;

  int total = 0;
  int bad = 0;
  logic [7:0] mdl [NB];

  always #10 clk = ~clk;

  bimem_port #(.ADDR_BITS(AB), .IO_BASE(IO_BASE)) u_dut (
    .clk(clk), .rstN(rstN), .bigEndian(bigEndian), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqSigned(reqSigned),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busError(busError),
    .rdValid(rdValid), .rdData(rdData), .ioWrite(ioWrite),
    .ioAddr(ioAddr), .ioData(ioData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic expErr(input logic [1:0] sz, input logic [31:0] a);
    logic [31:0] m;
    m = 32'(NB - 1);
    if (sz == 2'd1) m = m & ~32'd1;
    else if (sz[1]) m = m & ~32'd3;
    return (a & ~m) != 0;
  endfunction

  function automatic int nBytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  task automatic mdlWrite(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d, input logic be);
    int n;
    n = nBytes(sz);
    for (int k = 0; k < n; k++)
      mdl[(a + k) % NB] = be ? d[8*(n-1-k) +: 8] : d[8*k +: 8];
  endtask

  function automatic logic [31:0] mdlRead(input logic [1:0] sz, input logic sg, input logic [31:0] a, input logic be);
    int n;
    logic [31:0] v;
    n = nBytes(sz);
    v = '0;
    for (int k = 0; k < n; k++)
      if (be) v[8*(n-1-k) +: 8] = mdl[(a + k) % NB];
      else    v[8*k +: 8] = mdl[(a + k) % NB];
    if (sg && n == 1 && v[7])  v[31:8]  = '1;
    if (sg && n == 2 && v[15]) v[31:16] = '1;
    return v;
  endfunction

  // One access: drive at negedge, check combinational outputs, then the read result a cycle later.
  task automatic access(input logic wr, input logic [1:0] sz, input logic sg,
                        input logic [31:0] a, input logic [31:0] d, input string tag);
    logic e, io;
    logic [31:0] expData;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqSigned = sg;
    reqAddr = a; reqWdata = d;
    e  = expErr(sz, a);
    io = wr && sz == 2'd0 && a > IO_BASE;
    expData = mdlRead(sz, sg, a, bigEndian);
    #1;
    chk({tag, " R2 busError"}, 32'(busError), 32'(e));
    chk({tag, " R9 ioWrite"}, 32'(ioWrite), 32'(io));
    if (io) begin
      chk({tag, " R9 ioAddr"}, ioAddr, a);
      chk({tag, " R9 ioData"}, 32'(ioData), 32'(d[7:0]));
    end
    if (wr && !e) mdlWrite(sz, a, d, bigEndian);
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    chk({tag, " R7 rdValid"}, 32'(rdValid), 32'(!wr && !e));
    if (!wr && !e) chk({tag, " R7 rdData"}, rdData, expData);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NB; i++) mdl[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 rdValid after reset", 32'(rdValid), 32'd0);
    access(1'b0, 2'd2, 1'b0, 32'h0000_0100, '0, "R1 reset word zero");

    // R4 little-endian word, seen byte by byte
    bigEndian = 1'b0;
    access(1'b1, 2'd2, 1'b0, 32'h0000_0010, 32'h1122_3344, "R4 wr");
    access(1'b0, 2'd0, 1'b0, 32'h0000_0010, '0, "R4 lowest byte is LSB");
    access(1'b0, 2'd1, 1'b0, 32'h0000_0012, '0, "R4 upper half");
    // R5 big-endian word
    bigEndian = 1'b1;
    access(1'b1, 2'd2, 1'b0, 32'h0000_0020, 32'hA1B2_C3D4, "R5 wr");
    access(1'b0, 2'd0, 1'b0, 32'h0000_0020, '0, "R5 lowest byte is MSB");
    access(1'b0, 2'd2, 1'b0, 32'h0000_0020, '0, "R5 word back");
    access(1'b0, 2'd1, 1'b0, 32'h0000_0010, '0, "R5 BE half over LE data");
    // R6 bytes independent of mode
    access(1'b1, 2'd0, 1'b0, 32'h0000_0031, 32'h0000_005A, "R6 wr BE");
    bigEndian = 1'b0;
    access(1'b0, 2'd0, 1'b0, 32'h0000_0031, '0, "R6 read LE");
    // R2 / R3 misaligned and out-of-range writes dropped
    access(1'b1, 2'd2, 1'b0, 32'h0000_0042, 32'hDEAD_BEEF, "R3 misaligned word");
    access(1'b0, 2'd1, 1'b0, 32'h0000_0042, '0, "R3 unchanged");
    access(1'b1, 2'd0, 1'b0, 32'(NB) + 32'd5, 32'h0000_0077, "R3 out of range byte");
    access(1'b0, 2'd0, 1'b0, 32'h0000_0005, '0, "R3 no wrap write");
    access(1'b0, 2'd1, 1'b0, 32'h0000_0003, '0, "R2 odd half read");
    access(1'b0, 2'd3, 1'b0, 32'h0000_0012, '0, "R2 size3 as word");
    // R8 extension
    access(1'b1, 2'd1, 1'b0, 32'h0000_0050, 32'h0000_80F0, "R8 wr");
    access(1'b0, 2'd0, 1'b1, 32'h0000_0050, '0, "R8 signed byte");
    access(1'b0, 2'd0, 1'b0, 32'h0000_0050, '0, "R8 unsigned byte");
    access(1'b0, 2'd1, 1'b1, 32'h0000_0050, '0, "R8 signed half");
    access(1'b0, 2'd1, 1'b0, 32'h0000_0050, '0, "R8 unsigned half");
    // R9 I/O window
    access(1'b1, 2'd0, 1'b0, IO_BASE, 32'h0000_0041, "R9 at threshold");
    access(1'b1, 2'd0, 1'b0, IO_BASE + 32'd1, 32'h0000_0042, "R9 above threshold");
    access(1'b1, 2'd2, 1'b0, IO_BASE + 32'd4, 32'h0000_0043, "R9 word no io");
    access(1'b0, 2'd0, 1'b0, IO_BASE + 32'd2, '0, "R9 read no io");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] sz;
      logic [31:0] a;
      logic [31:0] r;
      r  = $urandom;
      sz = r[1:0];
      a  = $urandom % NB;
      if (r[4:2] != 3'd0) a = a & ~32'(nBytes(sz) - 1);
      if (r[7:5] == 3'd0) a = a | 32'(NB);
      if (r[10:8] == 3'd0) bigEndian = ~bigEndian;
      access(r[11], sz, r[12], a, $urandom, "R4/R5/R8 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule